// File: doc/BRIEF.md
# Configurable UART Transmit Serializer

This block turns one character at a time into an asynchronous serial frame on a single line output. A character is accepted with a load strobe while the block is idle. The block then sends one start bit, the data bits least significant first, an optional ninth bit, an optional parity bit and one stop bit. Each bit lasts sixteen periods of an oversampling baud tick.

The ninth bit does not come from the data byte. It comes from a held register that software writes separately. The same controls select the line coding. Plain NRZ can run with or without polarity inversion. A smart-card character mode inverts only the payload bits. An infrared option sends each zero as a short pulse in the middle of the bit.

The block also drives a pin output-enable for single-wire half-duplex use. A smart-card block counter clears the driving direction on its own once a block and its four trailing characters have been sent.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset the line is idle high (NRZ, no inversion), `ready` is 1, `done` is 0 and `line_oe` is 1.
- R2: A frame is a 0 start bit, the 8 data bits least significant bit first, then a 1 stop bit. Each bit holds for exactly 16 baud ticks, counted from the first tick after the load.
- R3: With `cfg_nine`=1 the bit sent after the data is the held ninth-bit register. It is written by `bit9_wr`/`bit9_val`, keeps its value between frames, and a load in the same cycle as a write still uses the old value.
- R4: With `cfg_par_en`=1 a parity bit follows the data (and the ninth bit if present). It is the XOR of those bits for even parity (`cfg_par_odd`=0) and its complement for odd parity.
- R5: With `cfg_invert`=1 and `cfg_card`=0 in NRZ mode, every level is inverted, including idle, start and stop.
- R6: With `cfg_card`=1 in NRZ mode, `cfg_invert` inverts only the data, ninth and parity bits. Idle, start and stop keep normal polarity.
- R7: With `cfg_irda`=1, a 0 bit is a pulse during ticks 7, 8 and 9 of its 16 (tick 0 is the bit's first). The pulse is high on an idle-low line when not inverted, and low on an idle-high line when `cfg_invert`=1. A 1 bit sends no pulse.
- R8: `ready` is 0 from the clock after an accepted load until the frame ends. A load strobe while `ready` is 0 is ignored.
- R9: `done` is high for exactly one clock, starting at the edge where the stop bit's 16th tick is taken. `ready` returns to 1 in that same cycle.
- R10: With `cfg_one_wire`=1, `line_oe` equals the direction bit written by `dir_wr`/`dir_val` (1 = output). With `cfg_one_wire`=0, `line_oe` is always 1.
- R11: `blk_wr` loads the block-length counter from `blk_len`. Each completed character decrements the counter while it is non-zero. With `cfg_card`=1 and `cfg_blk_mode`=1, the direction bit clears one clock after the fourth character completed with the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe at 16x the bit rate |
| load | input | 1 | Accept `data_in` when ready |
| data_in | input | 8 | Character data |
| bit9_wr | input | 1 | Write strobe for the held ninth bit |
| bit9_val | input | 1 | Ninth-bit value to store |
| cfg_nine | input | 1 | 9-bit data format |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_odd | input | 1 | Odd (1) or even (0) parity |
| cfg_invert | input | 1 | Polarity inversion |
| cfg_irda | input | 1 | Infrared pulse coding |
| cfg_one_wire | input | 1 | Single-wire half-duplex mode |
| cfg_card | input | 1 | Smart-card character mode |
| cfg_blk_mode | input | 1 | Smart-card block mode, enables auto release |
| dir_wr | input | 1 | Write strobe for the direction bit |
| dir_val | input | 1 | Direction value (1 = output) |
| blk_wr | input | 1 | Load the block-length counter |
| blk_len | input | 8 | Block length value |
| line_out | output | 1 | Serial line |
| line_oe | output | 1 | Pin output enable |
| ready | output | 1 | No frame in progress |
| done | output | 1 | One-clock frame-complete pulse |

## Verification
A wrong bit index or tick count shows on `line_out` within one bit time, as a level held for the wrong number of ticks or taken from the wrong position. A frame that runs long or short moves `done` and `ready` by at least a tick. A wrong ninth-bit register or direction state stays hidden until the next 9-bit frame or the next single-wire cycle, so the bench repeats frames and checks `line_oe` around the fourth trailing character. A behavioural model compares all four outputs on every clock, so any divergence is reported in the cycle it appears.

// File: rtl/uart_tx_pkg.sv
// Package: shared sizes for the transmit serializer.
// Assumes one start bit, one stop bit, at most one ninth bit and one parity bit.
package uart_tx_pkg;
    localparam int unsigned EXTRA_BITS = 4; // start, ninth, parity, stop
    function automatic int unsigned frame_width(input int unsigned data_w);
        return data_w + EXTRA_BITS;
    endfunction
endpackage

// File: rtl/uart_tx_shifter.sv
// Frame engine: captures a character on load while idle and steps through its
// bits, one bit every OVS baud ticks. Marks the payload bits (data, ninth,
// parity) for the line coder. Assumes the configuration is stable during a frame.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         baud_tick,
    input  logic                         load,
    input  logic [DATA_W-1:0]            data_in,
    input  logic                         bit9,
    input  logic                         cfg_nine,
    input  logic                         cfg_par_en,
    input  logic                         cfg_par_odd,
    output logic                         busy,
    output logic                         cur_bit,
    output logic                         cur_pay,
    output logic [$clog2(OVS)-1:0]       tick_cnt,
    output logic                         done
);
    localparam int unsigned FW = frame_width(DATA_W);
    localparam int unsigned IW = $clog2(FW);
    localparam int unsigned TW = $clog2(OVS);
    localparam logic [TW-1:0] TMAX = TW'(OVS - 1);

    logic [FW-1:0] frame_q, pay_q, new_frame, new_pay;
    logic [IW-1:0] idx_q, last_q, new_last;
    logic          par_bit;

    // Build the frame image and payload mask from the inputs.
    always_comb begin
        new_frame = '1;
        new_pay   = '0;
        new_frame[0] = 1'b0;
        for (int i = 0; i < int'(DATA_W); i++) begin
            new_frame[1+i] = data_in[i];
            new_pay[1+i]   = 1'b1;
        end
        par_bit  = (^data_in) ^ (cfg_nine & bit9) ^ cfg_par_odd;
        new_last = IW'(DATA_W + 1);
        if (cfg_nine) begin
            new_frame[new_last] = bit9;
            new_pay[new_last]   = 1'b1;
            new_last            = new_last + 1'b1;
        end
        if (cfg_par_en) begin
            new_frame[new_last] = par_bit;
            new_pay[new_last]   = 1'b1;
            new_last            = new_last + 1'b1;
        end
    end

    // Load, tick counting, bit stepping and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            tick_cnt <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            frame_q  <= '1;
            pay_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && load) begin
                busy     <= 1'b1;
                tick_cnt <= '0;
                idx_q    <= '0;
                last_q   <= new_last;
                frame_q  <= new_frame;
                pay_q    <= new_pay;
            end else if (busy && baud_tick) begin
                if (tick_cnt == TMAX) begin
                    tick_cnt <= '0;
                    if (idx_q == last_q) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

    assign cur_bit = busy ? frame_q[idx_q] : 1'b1;
    assign cur_pay = busy & pay_q[idx_q];

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> $stable(frame_q)); // R8
    AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx_q <= last_q)); // R2
endmodule

// File: rtl/uart_tx_line_coder.sv
// Line coder: maps the current bit to the line level for NRZ or infrared
// pulse coding and applies inversion (whole frame, or payload only in card mode).
// Assumes the tick counter restarts at zero at each bit boundary.
module uart_tx_line_coder #(
    parameter int unsigned OVS         = 16,
    parameter int unsigned PULSE_FIRST = 7,
    parameter int unsigned PULSE_LEN   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   busy,
    input  logic                   cur_bit,
    input  logic                   cur_pay,
    input  logic [$clog2(OVS)-1:0] tick_cnt,
    input  logic                   cfg_invert,
    input  logic                   cfg_irda,
    input  logic                   cfg_card,
    output logic                   line
);
    localparam int unsigned TW = $clog2(OVS);
    localparam logic [TW-1:0] P_LO = TW'(PULSE_FIRST);
    localparam logic [TW-1:0] P_HI = TW'(PULSE_FIRST + PULSE_LEN - 1);

    logic flip, pulse;

    // Choose the NRZ or pulse-coded level for this clock.
    always_comb begin
        flip  = cfg_invert & (~cfg_card | cur_pay);
        pulse = busy & ~cur_bit & (tick_cnt >= P_LO) & (tick_cnt <= P_HI);
        if (cfg_irda) line = pulse ^ cfg_invert;
        else          line = cur_bit ^ flip;
    end

    AST_CARD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_card && !cfg_irda) |-> line); // R6
endmodule

// File: rtl/uart_tx_dir_ctl.sv
// Direction control: holds the single-wire direction bit and the block-length
// counter, and clears the direction after the block plus four trailing
// characters when card block mode is on. Assumes done is a one-clock pulse.
module uart_tx_dir_ctl #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned TAIL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             dir_wr,
    input  logic             dir_val,
    input  logic             blk_wr,
    input  logic [CNT_W-1:0] blk_len,
    input  logic             auto_en,
    output logic             dir
);
    localparam int unsigned TLW = $clog2(TAIL + 1);
    localparam logic [TLW-1:0] TAIL_LAST = TLW'(TAIL - 1);
    localparam logic [TLW-1:0] TAIL_SAT  = TLW'(TAIL);

    logic [CNT_W-1:0] blk_cnt;
    logic [TLW-1:0]   tail_cnt;
    logic             release_now;

    assign release_now = done & auto_en & (blk_cnt == '0) & (tail_cnt == TAIL_LAST);

    // Block counter and trailing-character counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt  <= '0;
            tail_cnt <= '0;
        end else if (blk_wr) begin
            blk_cnt  <= blk_len;
            tail_cnt <= '0;
        end else if (done) begin
            if (blk_cnt != '0)            blk_cnt  <= blk_cnt - 1'b1;
            else if (tail_cnt != TAIL_SAT) tail_cnt <= tail_cnt + 1'b1;
        end
    end

    // Direction bit: software write wins over the automatic release.
    always_ff @(posedge clk) begin
        if (!rst_n)           dir <= 1'b0;
        else if (dir_wr)      dir <= dir_val;
        else if (release_now) dir <= 1'b0;
    end

    AST_BLK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !blk_wr && blk_cnt != '0) |=> (blk_cnt == $past(blk_cnt) - 1'b1)); // R11
    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tail_cnt <= TAIL_SAT); // R11
endmodule

// File: rtl/uart_tx_serializer.sv
// Top: configurable UART transmit serializer. Holds the ninth-bit register and
// joins the frame engine, line coder and direction control.
// Assumes baud_tick is a one-clock strobe at OVS times the bit rate.
module uart_tx_serializer #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bit9_wr,
    input  logic              bit9_val,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_invert,
    input  logic              cfg_irda,
    input  logic              cfg_one_wire,
    input  logic              cfg_card,
    input  logic              cfg_blk_mode,
    input  logic              dir_wr,
    input  logic              dir_val,
    input  logic              blk_wr,
    input  logic [CNT_W-1:0]  blk_len,
    output logic              line_out,
    output logic              line_oe,
    output logic              ready,
    output logic              done
);
    logic                   bit9_q, busy, cur_bit, cur_pay, dir;
    logic [$clog2(OVS)-1:0] tick_cnt;

    // Held ninth-bit register, kept across frames.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit9_q <= 1'b0;
        else if (bit9_wr) bit9_q <= bit9_val;
    end

    uart_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
        .data_in(data_in), .bit9(bit9_q), .cfg_nine(cfg_nine),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .busy(busy),
        .cur_bit(cur_bit), .cur_pay(cur_pay), .tick_cnt(tick_cnt), .done(done)
    );

    uart_tx_line_coder #(.OVS(OVS)) u_coder (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cur_bit(cur_bit),
        .cur_pay(cur_pay), .tick_cnt(tick_cnt), .cfg_invert(cfg_invert),
        .cfg_irda(cfg_irda), .cfg_card(cfg_card), .line(line_out)
    );

    uart_tx_dir_ctl #(.CNT_W(CNT_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .done(done), .dir_wr(dir_wr),
        .dir_val(dir_val), .blk_wr(blk_wr), .blk_len(blk_len),
        .auto_en(cfg_card & cfg_blk_mode), .dir(dir)
    );

    assign ready   = ~busy;
    assign line_oe = cfg_one_wire ? dir : 1'b1;

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready); // R9
    AST_LOAD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && load) |=> !ready); // R8
endmodule

// File: tb/uart_tx_serializer_bench.sv
// Bench: behavioural per-clock model (bit queues) compared on every clock.
module uart_tx_serializer_bench;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, load = 1'b0;
    logic [7:0] data_in = '0, blk_len = '0;
    logic bit9_wr = 0, bit9_val = 0, cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
    logic cfg_invert = 0, cfg_irda = 0, cfg_one_wire = 0, cfg_card = 0, cfg_blk_mode = 0;
    logic dir_wr = 0, dir_val = 0, blk_wr = 0;
    logic line_out, line_oe, ready, done;

    int checks = 0, errors = 0;
    string req = "R1";

    always #10 clk = ~clk;

    uart_tx_serializer u_uart_tx_serializer (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load), .data_in(data_in),
        .bit9_wr(bit9_wr), .bit9_val(bit9_val), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_invert(cfg_invert), .cfg_irda(cfg_irda),
        .cfg_one_wire(cfg_one_wire), .cfg_card(cfg_card), .cfg_blk_mode(cfg_blk_mode),
        .dir_wr(dir_wr), .dir_val(dir_val), .blk_wr(blk_wr), .blk_len(blk_len),
        .line_out(line_out), .line_oe(line_oe), .ready(ready), .done(done)
    );

    // Reference model state
    int  q_bit[$], q_pay[$];
    int  m_tick = 0, m_blk = 0, m_tail = 0;
    bit  m_busy = 0, m_done = 0, m_b9 = 0, m_dir = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_b9 = 0; m_dir = 0; m_tick = 0;
            m_blk = 0; m_tail = 0; q_bit.delete(); q_pay.delete();
        end else begin
            // direction and block counting use last cycle's completion
            if (blk_wr) begin m_blk = blk_len; m_tail = 0; end
            else if (m_done) begin
                if (m_blk > 0) m_blk--;
                else begin
                    if (m_tail == 3 && cfg_card && cfg_blk_mode && !dir_wr) m_dir = 0;
                    if (m_tail < 4) m_tail++;
                end
            end
            if (dir_wr) m_dir = dir_val;
            m_done = 0;
            if (!m_busy && load) begin
                int p;
                p = 0;
                q_bit.delete(); q_pay.delete();
                q_bit.push_back(0); q_pay.push_back(0);
                for (int i = 0; i < 8; i++) begin
                    q_bit.push_back(data_in[i]); q_pay.push_back(1); p ^= data_in[i];
                end
                if (cfg_nine) begin q_bit.push_back(m_b9); q_pay.push_back(1); p ^= m_b9; end
                if (cfg_par_en) begin q_bit.push_back(p ^ cfg_par_odd); q_pay.push_back(1); end
                q_bit.push_back(1); q_pay.push_back(0);
                m_busy = 1; m_tick = 0;
            end else if (m_busy && baud_tick) begin
                if (m_tick == 15) begin
                    m_tick = 0;
                    void'(q_bit.pop_front()); void'(q_pay.pop_front());
                    if (q_bit.size() == 0) begin m_busy = 0; m_done = 1; end
                end else m_tick++;
            end
            if (bit9_wr) m_b9 = bit9_val;
        end
    end

    function automatic bit exp_line();
        bit b, pay, pl;
        b   = m_busy ? q_bit[0][0] : 1'b1;
        pay = m_busy ? q_pay[0][0] : 1'b0;
        if (cfg_irda) begin
            pl = m_busy && !b && m_tick >= 7 && m_tick <= 9;
            return pl ^ cfg_invert;
        end
        if (cfg_invert && (!cfg_card || pay)) return !b;
        return b;
    endfunction

    task automatic check(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    // Compare all outputs a quarter cycle after each edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            check(req, "line_out", line_out, exp_line());
            check("R10", "line_oe", line_oe, cfg_one_wire ? m_dir : 1);
            check("R8", "ready", ready, !m_busy);
            check("R9", "done", done, m_done);
        end
    end

    // Baud tick every second clock.
    always @(negedge clk) baud_tick <= ~baud_tick;

    task automatic send(input logic [7:0] d);
        while (!ready) @(negedge clk);
        data_in = d; load = 1;
        @(negedge clk); load = 0;
        while (!ready) @(negedge clk);
    endtask

    task automatic pulse_bit9(input bit v);
        @(negedge clk); bit9_val = v; bit9_wr = 1;
        @(negedge clk); bit9_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "line_out reset", line_out, 1);
        check("R1", "ready reset", ready, 1);
        check("R1", "done reset", done, 0);
        check("R1", "line_oe reset", line_oe, 1);
        rst_n = 1;
        repeat (4) @(negedge clk);

        req = "R2"; send(8'hA5); send(8'h01);
        // R8: load while busy ignored
        req = "R8";
        @(negedge clk); data_in = 8'h3C; load = 1; @(negedge clk); load = 0;
        repeat (100) @(negedge clk);
        data_in = 8'h00; load = 1; @(negedge clk); load = 0;
        while (!ready) @(negedge clk);

        req = "R4"; cfg_par_en = 1; send(8'h37); cfg_par_odd = 1; send(8'h37);
        cfg_par_en = 0; cfg_par_odd = 0;

        // R3: ninth bit held across frames, write in load cycle uses old value
        req = "R3"; cfg_nine = 1; pulse_bit9(1); send(8'h55); send(8'h0F);
        @(negedge clk); bit9_val = 0; bit9_wr = 1; data_in = 8'hF0; load = 1;
        @(negedge clk); bit9_wr = 0; load = 0;
        while (!ready) @(negedge clk);
        send(8'hF0);
        req = "R4"; cfg_par_en = 1; pulse_bit9(1); send(8'h81); cfg_par_en = 0; cfg_nine = 0;

        req = "R5"; cfg_invert = 1; repeat (5) @(negedge clk); send(8'hC3);
        req = "R6"; cfg_card = 1; cfg_par_en = 1; repeat (5) @(negedge clk); send(8'hC3);
        cfg_par_en = 0; cfg_invert = 0; cfg_card = 0;

        req = "R7"; cfg_irda = 1; repeat (5) @(negedge clk); send(8'h5A);
        cfg_invert = 1; repeat (5) @(negedge clk); send(8'h5A);
        cfg_irda = 0; cfg_invert = 0;

        // R10: single-wire direction
        req = "R10"; cfg_one_wire = 1; repeat (3) @(negedge clk);
        check("R10", "oe dir=0", line_oe, 0);
        dir_val = 1; dir_wr = 1; @(negedge clk); dir_wr = 0; @(negedge clk);
        check("R10", "oe dir=1", line_oe, 1);

        // R11: block of 2 then four trailing characters releases direction
        req = "R11"; cfg_card = 1; cfg_blk_mode = 1;
        blk_len = 8'd2; blk_wr = 1; @(negedge clk); blk_wr = 0;
        for (int k = 0; k < 5; k++) send(8'(k + 8'h10));
        @(negedge clk);
        check("R11", "oe after 5 chars", line_oe, 1);
        send(8'h99);
        @(negedge clk);
        check("R11", "oe after 6 chars", line_oe, 0);
        cfg_one_wire = 0; @(negedge clk);
        check("R10", "oe outside single-wire", line_oe, 1);
        repeat (10) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule